// File: doc/BRIEF.md
# Dual-Port Collision Alert Generator

This block watches the two access ports of a synchronous dual-port RAM that share one clock. Each port presents an enable, a write strobe and an address. When both ports touch the same address in the same cycle, the block uses the read/write mix to decide which port's data may be unreliable. It then raises an active-low alert on that port.

Each alert is delayed to a fixed later clock edge and held low for exactly one cycle. The cycle after it is spent returning the alert to its idle level, so software never has to clear it. A colliding access that would land during that clearing cycle produces no alert. For this reason a long run of colliding accesses produces an alert on every other cycle. Each port has its own delay pipeline and its own alert state, so the two alerts behave independently. The memory array and any retry policy lie outside this block.

Top module: `dpc_alert_gen`

## Requirements
- R1: While reset is high and on the first edge after it, both alert outputs are high (1 = no alert).
- R2: An alert never goes low unless that port was at risk in the access sampled ALERT_LAT-1 edges earlier. This covers different addresses on the two ports and a disabled port (enable 0).
- R3: When both ports are enabled with equal addresses and both have write strobe 0 (read), neither alert goes low.
- R4: When one port writes (write strobe 1) and the other reads at the same address, the reading port's alert goes low and the writing port's alert stays high.
- R5: When both ports write to the same address, both alerts go low.
- R6: Timing. Count the edge that samples the colliding access as edge 1. The alert falls at edge ALERT_LAT (default 2) and rises again at the following edge, so it is low for exactly one cycle.
- R7: A port that is at risk but whose alert is low at the edge where a new alert would fall gets no alert from that access (recovery cycle). With three consecutive collisions, the first and third alert and the second does not.
- R8: Under an unbroken run of colliding writes on both ports, each alert alternates low and high every cycle.
- R9: The two alerts are independent. One port's recovery cycle does not suppress an alert due on the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| pa_en | input | 1 | Port A access enable |
| pa_we | input | 1 | Port A write strobe (1 = write, 0 = read) |
| pa_addr | input | ADDR_W | Port A address |
| pb_en | input | 1 | Port B access enable |
| pb_we | input | 1 | Port B write strobe (1 = write, 0 = read) |
| pb_addr | input | ADDR_W | Port B address |
| pa_alert_n | output | 1 | Port A collision alert, active low, registered |
| pb_alert_n | output | 1 | Port B collision alert, active low, registered |

## Verification
The hardest situation to reach from the ports is a collision that lands exactly on a port's recovery cycle while the other port is armed. Only there do the swallowing rule and per-port independence show up. The stimulus creates it deliberately: a write/read collision arms one port, and a write/write collision follows on the very next cycle. This is followed by back-to-back and triple collisions and a long colliding burst, all on an exact per-cycle schedule. A reference model in the bench predicts each alert level from these rules alone.

// File: rtl/dpc_alert_pkg.sv
package dpc_alert_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  typedef enum logic {
    AL_ARMED = 1'b0,
    AL_FIRED = 1'b1
  } al_state_e;

  localparam int NUM_PORTS = 2;

  function automatic acc_e classify(input logic en, input logic we);
    if (!en)      return ACC_IDLE;
    else if (we)  return ACC_WRITE;
    else          return ACC_READ;
  endfunction

  // A port's data is in doubt when it is active and the opposite port writes.
  function automatic logic port_at_risk(input acc_e own, input acc_e other);
    return (own != ACC_IDLE) && (other == ACC_WRITE);
  endfunction

endpackage

// File: rtl/dpc_access_decode.sv
module dpc_access_decode
  import dpc_alert_pkg::*;
(
  input  logic en,
  input  logic we,
  output acc_e kind
);

  always_comb begin
    kind = classify(en, we);
  end

endmodule

// File: rtl/dpc_collide.sv
module dpc_collide
  import dpc_alert_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  acc_e                                kind [NUM_PORTS],
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    addr,
  output logic [NUM_PORTS-1:0]                risk
);

  logic same_addr;

  always_comb begin
    same_addr = (addr[0] == addr[1]);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_risk
    localparam int OTHER = NUM_PORTS - 1 - p;
    always_comb begin
      risk[p] = same_addr && port_at_risk(kind[p], kind[OTHER]);
    end
  end

endmodule

// File: rtl/dpc_alert_pipe.sv
module dpc_alert_pipe
  import dpc_alert_pkg::*;
#(
  parameter int ALERT_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic risk_in,
  output logic alert_n
);

  localparam int STAGES = ALERT_LAT - 1;

  logic [STAGES-1:0] stg;
  logic              due;
  al_state_e         state;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) stg <= '0;
      else     stg <= risk_in;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stg <= '0;
      else     stg <= {stg[STAGES-2:0], risk_in};
    end
  end

  assign due = stg[STAGES-1];

  // Alert lasts one cycle; the edge ending it is the recovery edge,
  // where a newly due event is dropped.
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= AL_ARMED;
    end else begin
      case (state)
        AL_ARMED: state <= due ? AL_FIRED : AL_ARMED;
        AL_FIRED: state <= AL_ARMED;
        default:  state <= AL_ARMED;
      endcase
    end
  end

  assign alert_n = (state != AL_FIRED);

endmodule

// File: rtl/dpc_alert_gen.sv
module dpc_alert_gen
  import dpc_alert_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int ALERT_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pa_en,
  input  logic              pa_we,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic              pb_en,
  input  logic              pb_we,
  input  logic [ADDR_W-1:0] pb_addr,
  output logic              pa_alert_n,
  output logic              pb_alert_n
);

  logic [NUM_PORTS-1:0]             en_v;
  logic [NUM_PORTS-1:0]             we_v;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
  acc_e                             kind_v [NUM_PORTS];
  logic [NUM_PORTS-1:0]             risk_v;
  logic [NUM_PORTS-1:0]             alert_v;

  assign en_v   = {pb_en, pa_en};
  assign we_v   = {pb_we, pa_we};
  assign addr_v = {pb_addr, pa_addr};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpc_access_decode u_dec (
      .en   (en_v[p]),
      .we   (we_v[p]),
      .kind (kind_v[p])
    );

    dpc_alert_pipe #(.ALERT_LAT(ALERT_LAT)) u_pipe (
      .clk     (clk),
      .rst     (rst),
      .risk_in (risk_v[p]),
      .alert_n (alert_v[p])
    );
  end

  dpc_collide #(.ADDR_W(ADDR_W)) u_collide (
    .kind (kind_v),
    .addr (addr_v),
    .risk (risk_v)
  );

  assign pa_alert_n = alert_v[0];
  assign pb_alert_n = alert_v[1];

endmodule

// File: rtl/dpc_alert_gen_chk.sv
module dpc_alert_gen_chk #(
  parameter int ADDR_W    = 18,
  parameter int ALERT_LAT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pa_en,
  input logic              pa_we,
  input logic [ADDR_W-1:0] pa_addr,
  input logic              pb_en,
  input logic              pb_we,
  input logic [ADDR_W-1:0] pb_addr,
  input logic              pa_alert_n,
  input logic              pb_alert_n
);

  localparam int L = ALERT_LAT;

  logic         same;
  logic [L-1:0] ra_d, rb_d, rr_d;
  logic         pa_q, pb_q;

  assign same = pa_en && pb_en && (pa_addr == pb_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_d <= '0;
      rb_d <= '0;
      rr_d <= '0;
      pa_q <= 1'b1;
      pb_q <= 1'b1;
    end else begin
      ra_d <= {ra_d[L-2:0], same && pb_we};
      rb_d <= {rb_d[L-2:0], same && pa_we};
      rr_d <= {rr_d[L-2:0], same && !pa_we && !pb_we};
      pa_q <= pa_alert_n;
      pb_q <= pb_alert_n;
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> (pa_alert_n && pb_alert_n));

  p_no_spurious_a_r2: assert property (@(posedge clk) disable iff (rst)
    !pa_alert_n |-> ra_d[L-1]);
  p_no_spurious_b_r2: assert property (@(posedge clk) disable iff (rst)
    !pb_alert_n |-> rb_d[L-1]);

  p_read_pair_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    rr_d[L-1] |-> (pa_alert_n && pb_alert_n));

  // R4 and R5: an at-risk port that is armed must alert
  p_fire_a_r4: assert property (@(posedge clk) disable iff (rst)
    (ra_d[L-1] && pa_q) |-> !pa_alert_n);
  p_fire_b_r5: assert property (@(posedge clk) disable iff (rst)
    (rb_d[L-1] && pb_q) |-> !pb_alert_n);

  p_single_cycle_a_r6: assert property (@(posedge clk) disable iff (rst)
    !pa_alert_n |=> pa_alert_n);
  p_single_cycle_b_r6: assert property (@(posedge clk) disable iff (rst)
    !pb_alert_n |=> pb_alert_n);

  p_swallow_a_r7: assert property (@(posedge clk) disable iff (rst)
    (ra_d[L-1] && !pa_q) |-> pa_alert_n);
  p_swallow_b_r7: assert property (@(posedge clk) disable iff (rst)
    (rb_d[L-1] && !pb_q) |-> pb_alert_n);

endmodule

bind dpc_alert_gen dpc_alert_gen_chk #(
  .ADDR_W    (ADDR_W),
  .ALERT_LAT (ALERT_LAT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pa_en      (pa_en),
  .pa_we      (pa_we),
  .pa_addr    (pa_addr),
  .pb_en      (pb_en),
  .pb_we      (pb_we),
  .pb_addr    (pb_addr),
  .pa_alert_n (pa_alert_n),
  .pb_alert_n (pb_alert_n)
);

// File: tb/dpc_alert_gen_bench.sv
`timescale 1ns/1ps
module dpc_alert_gen_bench;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pa_en = 1'b0, pa_we = 1'b0, pb_en = 1'b0, pb_we = 1'b0;
  logic [AW-1:0] pa_addr = '0, pb_addr = '0;
  logic          pa_alert_n, pb_alert_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  logic [1:0] exp_q [$];   // {b_risk, a_risk} per driven cycle
  string      tag_q [$];

  always #5 clk = ~clk;

  dpc_alert_gen #(.ADDR_W(AW), .ALERT_LAT(2)) u_dpc_alert_gen (
    .clk(clk), .rst(rst),
    .pa_en(pa_en), .pa_we(pa_we), .pa_addr(pa_addr),
    .pb_en(pb_en), .pb_we(pb_we), .pb_addr(pb_addr),
    .pa_alert_n(pa_alert_n), .pb_alert_n(pb_alert_n)
  );

  task automatic check(input logic act, input logic exp, input string what, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: one call per cycle; pushes the at-risk pair predicted by R2..R5.
  task automatic drive(input logic ae, input logic aw, input logic [AW-1:0] aa,
                       input logic be, input logic bw, input logic [AW-1:0] ba,
                       input string tag);
    logic same;
    @(negedge clk);
    pa_en = ae; pa_we = aw; pa_addr = aa;
    pb_en = be; pb_we = bw; pb_addr = ba;
    same = ae && be && (aa == ba);
    exp_q.push_back({same && aw, same && bw});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, "R2");
  endtask

  // Monitor: model of delay, one-cycle pulse and recovery (R6, R7).
  logic [1:0] m_stage = 2'b00;
  logic [1:0] m_out   = 2'b00;
  string      m_tag   = "R1";
  always @(posedge clk) begin
    logic [1:0] popped;
    string      ptag;
    #1;
    if (rst) begin
      m_stage = 2'b00; m_out = 2'b00; m_tag = "R1";
      exp_q.delete(); tag_q.delete();
    end else begin
      popped = 2'b00; ptag = "R2";
      if (exp_q.size() > 0) begin
        popped = exp_q.pop_front();
        ptag   = tag_q.pop_front();
      end
      m_out   = m_stage & ~m_out;
      check(pa_alert_n, ~m_out[0], "port A alert", m_tag);
      check(pb_alert_n, ~m_out[1], "port B alert", m_tag);
      m_stage = popped;
      m_tag   = ptag;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(pa_alert_n, 1'b1, "A in reset", "R1");
    check(pb_alert_n, 1'b1, "B in reset", "R1");
    @(negedge clk);
    rst = 1'b0;
    exp_q.push_back(2'b00); tag_q.push_back("R1");
    idle(2);

    // R2: different addresses, disabled port
    drive(1, 1, 18'h00010, 1, 1, 18'h00011, "R2");
    drive(0, 1, 18'h00020, 1, 1, 18'h00020, "R2");
    drive(1, 0, 18'h00030, 0, 1, 18'h00030, "R2");
    idle(3);
    // R3: both read
    drive(1, 0, 18'h3FFFF, 1, 0, 18'h3FFFF, "R3");
    idle(3);
    // R4: write/read each way
    drive(1, 1, 18'h00100, 1, 0, 18'h00100, "R4");
    idle(3);
    drive(1, 0, 18'h00200, 1, 1, 18'h00200, "R4");
    idle(3);
    // R5 / R6: isolated double write
    drive(1, 1, 18'h3FFFE, 1, 1, 18'h3FFFE, "R5");
    idle(4);
    // R7: two, then three consecutive collisions
    drive(1, 1, 18'h00300, 1, 1, 18'h00300, "R7");
    drive(1, 1, 18'h00301, 1, 1, 18'h00301, "R7");
    idle(4);
    for (int i = 0; i < 3; i++) drive(1, 1, 18'h00400 + i, 1, 1, 18'h00400 + i, "R7");
    idle(4);
    // R8: long colliding burst
    for (int i = 0; i < 9; i++) drive(1, 1, 18'h01000 + i, 1, 1, 18'h01000 + i, "R8");
    idle(4);
    // R9: B alerts, then next-cycle double write alerts A only
    drive(1, 1, 18'h00500, 1, 0, 18'h00500, "R9");
    drive(1, 1, 18'h00501, 1, 1, 18'h00501, "R9");
    idle(4);
    // R9 mirrored
    drive(1, 0, 18'h00600, 1, 1, 18'h00600, "R9");
    drive(1, 1, 18'h00601, 1, 1, 18'h00601, "R9");
    idle(4);
    // R1: reset mid-alert clears outputs
    drive(1, 1, 18'h00700, 1, 1, 18'h00700, "R1");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #2;
    check(pa_alert_n, 1'b1, "A after reset", "R1");
    check(pb_alert_n, 1'b1, "B after reset", "R1");
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule